// File: doc/BRIEF.md
# NAND Bank Strobe Sequencer

This block turns single host bus transfers into timed strobe cycles on one NAND flash bank. A small register file holds a control word and two timing words. The control word carries the bank enable, wait-on-ready, device type, bus width, ECC settings and the two read turnaround delays. The two timing words, one for common space and one for attribute space, give the setup, strobe, hold and bus-release lengths of every flash cycle.

The host address picks a window. The register window reaches the register file, which answers in the same cycle. The data, command and address windows each start one flash cycle. A write in the command window raises CLE and a write in the address window raises ALE. A read in any flash window is a plain data read. One address bit picks attribute timing instead of common timing. A read that follows a command or address cycle first waits out a programmable turnaround delay.

The sequencer is one state machine with the states IDLE, DELAY, SETUP, STROBE, HOLD, RELEASE and DONE. The transitions are:
- IDLE to DELAY: a read whose turnaround count is non-zero.
- IDLE to SETUP: any other accepted access.
- DELAY to SETUP, and SETUP to STROBE: when the phase counter reaches zero.
- STROBE to HOLD, to RELEASE or to DONE: the first phase whose count is non-zero, otherwise DONE. HOLD to RELEASE or to DONE follows the same rule.
- RELEASE to DONE: when the counter reaches zero.
- DONE to IDLE: always, after one cycle that acknowledges the host.

Top module: `nand_bank_seq`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are 1, nand_cle, nand_ale and nand_dq_oe are 0. The control register reads 0, and both timing registers read 0x01040600 (release 1, hold 4, strobe 6, setup 0).
- R2: Address bits 9:8 = 00 select the register window, and host_ack is high in the same cycle as the request. The control word sits at offset 0x00, common timing at 0x08 and attribute timing at 0x0C. Control bits 5, 8 and 31:17 read as 0. Every other offset reads 0 and ignores writes.
- R3: nand_ce_n is the inverse of control bit 2 (bank enable).
- R4: Address bits 9:8 pick the flash window: 01 is data, 10 is command (CLE high) and 11 is address (ALE high). Address bit 10 = 1 selects attribute timing, 0 selects common timing. Reads never raise CLE or ALE.
- R5: A write keeps the data bus driven, and CLE or ALE asserted, for setup+1 cycles. It then holds WE low for strobe+1 cycles, then keeps the bus for hold more cycles. The bus is then released for the number of release cycles before host_ack. Timing word fields are setup 7:0, strobe 15:8, hold 23:16 and release 31:24.
- R6: A read holds RE low for strobe+1 cycles after setup+1 idle-strobe cycles. It samples nand_dq_in in the last RE-low cycle and returns it on host_rdata with host_ack.
- R7: A read whose previous flash cycle was a command write waits tCLR cycles (control bits 12:9) before its setup phase. After an address write it waits tAR cycles (control bits 16:13). After a data write or a read it adds no wait.
- R8: When control bit 1 (wait-on-ready) is set and nand_rb_n is low, no flash access starts and host_ack stays low. Register accesses are still served. When bit 1 is clear, nand_rb_n has no effect.
- R9: When control bit 4 is 1, data-window cycles move all 16 bits. Command and address cycles, and every cycle in 8-bit mode, drive and return only the low byte, with the upper byte 0.
- R10: WE and RE are never low together, CLE and ALE are never high together, and the bus is never driven while RE is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Transfer request, held until host_ack |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Bit 10 selects attribute space, bits 9:8 select the window, bits 7:0 are the register offset |
| host_wdata | input | 32 | Write data |
| host_ack | output | 1 | Transfer complete in this cycle |
| host_rdata | output | 32 | Read data, valid with host_ack |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data driven to the flash |
| nand_dq_oe | output | 1 | Data output enable |
| nand_dq_in | input | 16 | Data from the flash |
| nand_rb_n | input | 1 | Ready (1) / busy (0) from the flash |

## Verification
The hardest situation to reach is a read whose turnaround delay depends on the kind of the previous flash cycle. Several back-to-back requests combine timing values, windows and spaces, and each of these changes the expected strobe positions. Random sequences of configuration writes, command, address and data writes and reads reach these orderings under a fixed seed. A bench model tracks the last flash cycle kind and both timing words to predict each phase length. Directed cases hold the ready line low under wait-on-ready for a known number of cycles, and push all-ones into the control word to expose the reserved bits.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        WIN_REG  = 2'b00,
        WIN_DATA = 2'b01,
        WIN_CMD  = 2'b10,
        WIN_ADDR = 2'b11
    } win_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RELEASE,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic [7:0] release_c;
        logic [7:0] hold_c;
        logic [7:0] strobe_c;
        logic [7:0] setup_c;
    } timing_t;

    localparam int CTRL_WAITON_BIT = 1;
    localparam int CTRL_EN_BIT     = 2;
    localparam int CTRL_WIDE_BIT   = 4;
    localparam int CTRL_TCLR_LSB   = 9;
    localparam int CTRL_TAR_LSB    = 13;
    localparam int TURN_W          = 4;

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
    import nand_seq_pkg::*;
#(
    parameter int          HOST_W      = 32,
    parameter int          OFF_W       = 8,
    parameter logic [31:0] TIM_DEFAULT = 32'h0104_0600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  offset,
    input  logic [HOST_W-1:0] wdata,
    output logic [HOST_W-1:0] rdata,
    output logic [HOST_W-1:0] ctrl_q,
    output timing_t           tim_common,
    output timing_t           tim_attr
);

    localparam logic [OFF_W-1:0]  OFF_CTRL   = OFF_W'(8'h00);
    localparam logic [OFF_W-1:0]  OFF_COMMON = OFF_W'(8'h08);
    localparam logic [OFF_W-1:0]  OFF_ATTR   = OFF_W'(8'h0C);
    localparam logic [HOST_W-1:0] CTRL_MASK  = HOST_W'(32'h0001_FEDF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            tim_common <= timing_t'(TIM_DEFAULT);
            tim_attr   <= timing_t'(TIM_DEFAULT);
        end else if (wr_en) begin
            unique case (offset)
                OFF_CTRL:   ctrl_q     <= wdata & CTRL_MASK;
                OFF_COMMON: tim_common <= timing_t'(wdata[31:0]);
                OFF_ATTR:   tim_attr   <= timing_t'(wdata[31:0]);
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (offset)
            OFF_CTRL:   rdata = ctrl_q;
            OFF_COMMON: rdata = HOST_W'(tim_common);
            OFF_ATTR:   rdata = HOST_W'(tim_attr);
            default:    rdata = '0;
        endcase
    end

    // R2
    reserved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_MASK) == '0);

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_wr,
    input  win_e              req_win,
    input  timing_t           req_tim,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic              wide,
    input  logic [TURN_W-1:0] tclr,
    input  logic [TURN_W-1:0] tar,
    input  logic [DQ_W-1:0]   dq_in,
    output logic              fsm_idle,
    output logic              fsm_done,
    output logic [DQ_W-1:0]   rd_data,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe
);

    localparam int HALF = DQ_W / 2;

    state_e          state, state_nx;
    logic [7:0]      cnt, cnt_nx;
    logic            op_wr;
    win_e            op_win;
    logic            op_wide;
    timing_t         op_tim;
    logic [DQ_W-1:0] op_data;
    win_e            last_kind;
    logic [DQ_W-1:0] rd_q;

    // turnaround before a read, chosen by the previous flash cycle
    logic [TURN_W-1:0] turn;
    always_comb begin
        unique case (last_kind)
            WIN_CMD:  turn = tclr;
            WIN_ADDR: turn = tar;
            default:  turn = '0;
        endcase
    end

    // next state and phase counter
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (!req_wr && turn != '0) begin
                        state_nx = ST_DELAY;
                        cnt_nx   = 8'(turn) - 8'd1;
                    end else begin
                        state_nx = ST_SETUP;
                        cnt_nx   = req_tim.setup_c;
                    end
                end
            end
            ST_DELAY: begin
                if (cnt == '0) begin
                    state_nx = ST_SETUP;
                    cnt_nx   = op_tim.setup_c;
                end else cnt_nx = cnt - 8'd1;
            end
            ST_SETUP: begin
                if (cnt == '0) begin
                    state_nx = ST_STROBE;
                    cnt_nx   = op_tim.strobe_c;
                end else cnt_nx = cnt - 8'd1;
            end
            ST_STROBE: begin
                if (cnt == '0) begin
                    if (op_tim.hold_c != '0) begin
                        state_nx = ST_HOLD;
                        cnt_nx   = op_tim.hold_c - 8'd1;
                    end else if (op_tim.release_c != '0) begin
                        state_nx = ST_RELEASE;
                        cnt_nx   = op_tim.release_c - 8'd1;
                    end else state_nx = ST_DONE;
                end else cnt_nx = cnt - 8'd1;
            end
            ST_HOLD: begin
                if (cnt == '0) begin
                    if (op_tim.release_c != '0) begin
                        state_nx = ST_RELEASE;
                        cnt_nx   = op_tim.release_c - 8'd1;
                    end else state_nx = ST_DONE;
                end else cnt_nx = cnt - 8'd1;
            end
            ST_RELEASE: begin
                if (cnt == '0) state_nx = ST_DONE;
                else cnt_nx = cnt - 8'd1;
            end
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register and operation latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            op_wr     <= 1'b0;
            op_win    <= WIN_DATA;
            op_wide   <= 1'b0;
            op_tim    <= '0;
            op_data   <= '0;
            last_kind <= WIN_DATA;
            rd_q      <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            if (state == ST_IDLE && start) begin
                op_wr     <= req_wr;
                op_win    <= req_wr ? req_win : WIN_DATA;
                op_wide   <= wide;
                op_tim    <= req_tim;
                op_data   <= (wide && req_win == WIN_DATA) ? req_wdata
                             : {{(DQ_W-HALF){1'b0}}, req_wdata[HALF-1:0]};
                last_kind <= req_wr ? req_win : WIN_DATA;
            end
            if (state == ST_STROBE && cnt == '0 && !op_wr)
                rd_q <= op_wide ? dq_in : {{(DQ_W-HALF){1'b0}}, dq_in[HALF-1:0]};
        end
    end

    // pin outputs decoded from the state
    logic drive_ph;
    always_comb begin
        drive_ph = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        cle      = drive_ph && op_win == WIN_CMD;
        ale      = drive_ph && op_win == WIN_ADDR;
        we_n     = !(state == ST_STROBE && op_wr);
        re_n     = !(state == ST_STROBE && !op_wr);
        dq_oe    = drive_ph && op_wr;
        dq_out   = dq_oe ? op_data : '0;
        fsm_idle = (state == ST_IDLE);
        fsm_done = (state == ST_DONE);
        rd_data  = rd_q;
    end

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    // R10
    role_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    // R10
    bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);
    // R5
    we_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dq_oe);
    // R5
    done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_done |-> ($past(state) == ST_STROBE || $past(state) == ST_HOLD
                      || $past(state) == ST_RELEASE));
    // R4
    read_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> (!cle && !ale));

endmodule

// File: rtl/nand_bank_seq.sv
module nand_bank_seq
    import nand_seq_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter int          HOST_W      = 32,
    parameter int          DQ_W        = 16,
    parameter int          WIN_LSB     = 8,
    parameter logic [31:0] TIM_DEFAULT = 32'h0104_0600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [HOST_W-1:0] host_rdata,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DQ_W-1:0]   nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DQ_W-1:0]   nand_dq_in,
    input  logic              nand_rb_n
);

    localparam int ATTR_BIT = WIN_LSB + 2;

    win_e              win;
    logic              attr_sel;
    logic              reg_hit;
    logic              nand_hit;
    logic              start;
    logic              fsm_idle;
    logic              fsm_done;
    logic [HOST_W-1:0] reg_rdata;
    logic [HOST_W-1:0] ctrl_q;
    logic [DQ_W-1:0]   rd_data;
    timing_t           tim_common;
    timing_t           tim_attr;
    timing_t           tim_sel;
    logic              stall;

    assign win      = win_e'(host_addr[WIN_LSB+1:WIN_LSB]);
    assign attr_sel = host_addr[ATTR_BIT];
    assign reg_hit  = host_req && win == WIN_REG;
    assign nand_hit = host_req && win != WIN_REG;
    assign tim_sel  = attr_sel ? tim_attr : tim_common;
    assign stall    = ctrl_q[CTRL_WAITON_BIT] && !nand_rb_n;
    assign start    = nand_hit && fsm_idle && !stall;

    assign host_ack   = reg_hit || fsm_done;
    assign host_rdata = reg_hit ? reg_rdata : HOST_W'(rd_data);
    assign nand_ce_n  = !ctrl_q[CTRL_EN_BIT];

    nand_seq_regs #(
        .HOST_W      (HOST_W),
        .OFF_W       (WIN_LSB),
        .TIM_DEFAULT (TIM_DEFAULT)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_hit && host_wr),
        .offset     (host_addr[WIN_LSB-1:0]),
        .wdata      (host_wdata),
        .rdata      (reg_rdata),
        .ctrl_q     (ctrl_q),
        .tim_common (tim_common),
        .tim_attr   (tim_attr)
    );

    nand_seq_fsm #(
        .DQ_W (DQ_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_wr    (host_wr),
        .req_win   (win),
        .req_tim   (tim_sel),
        .req_wdata (host_wdata[DQ_W-1:0]),
        .wide      (ctrl_q[CTRL_WIDE_BIT]),
        .tclr      (ctrl_q[CTRL_TCLR_LSB +: TURN_W]),
        .tar       (ctrl_q[CTRL_TAR_LSB +: TURN_W]),
        .dq_in     (nand_dq_in),
        .fsm_idle  (fsm_idle),
        .fsm_done  (fsm_done),
        .rd_data   (rd_data),
        .cle       (nand_cle),
        .ale       (nand_ale),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .dq_out    (nand_dq_out),
        .dq_oe     (nand_dq_oe)
    );

    // R8
    ready_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_hit && fsm_idle && ctrl_q[CTRL_WAITON_BIT] && !nand_rb_n) |=> fsm_idle);
    // R8
    stall_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_idle && !reg_hit) |-> !host_ack);

endmodule

// File: tb/nand_bank_seq_tb_top.sv
module nand_bank_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] nand_dq_out;
    logic [15:0] nand_dq_in = '0;
    logic        nand_rb_n = 1'b1;

    int checks = 0;
    int errors = 0;

    logic [31:0] ctrl_sh, com_sh, att_sh;
    logic [1:0]  last_kind;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_bank_seq dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
    );

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] tim_of(input logic attr);
        return attr ? att_sh : com_sh;
    endfunction

    function automatic int turn_of(input logic [1:0] kind);
        if (kind == 2'b10) return int'(ctrl_sh[12:9]);
        if (kind == 2'b11) return int'(ctrl_sh[16:13]);
        return 0;
    endfunction

    function automatic int cycle_total(input logic [31:0] t, input int delay);
        return 1 + delay + int'(t[7:0]) + 1 + int'(t[15:8]) + 1 + int'(t[23:16]) + int'(t[31:24]);
    endfunction

    // one host transfer with pin monitoring
    task automatic access(input logic wr, input logic [11:0] addr, input logic [31:0] wd,
                          input int rb_rel, output int total, output int we_lo,
                          output int re_lo, output int oe_n, output int cle_n,
                          output int ale_n, output int first_re, output logic [15:0] wval,
                          output logic [31:0] rd, output int bad);
        int idx;
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = addr; host_wdata = wd;
        idx = 0; we_lo = 0; re_lo = 0; oe_n = 0; cle_n = 0; ale_n = 0;
        first_re = -1; wval = '0; bad = 0;
        forever begin
            #1;
            if (host_ack) break;
            if (!nand_we_n) begin we_lo++; wval = nand_dq_out; end
            if (!nand_re_n) begin re_lo++; if (first_re < 0) first_re = idx; end
            if (nand_dq_oe) oe_n++;
            if (nand_cle) cle_n++;
            if (nand_ale) ale_n++;
            if ((!nand_we_n && !nand_re_n) || (nand_cle && nand_ale) ||
                (!nand_re_n && nand_dq_oe)) bad++;
            idx++;
            if (idx == rb_rel) nand_rb_n = 1'b1;
            if (idx > 5000) break;
            @(negedge clk);
        end
        rd = host_rdata;
        total = idx;
        @(posedge clk);
        #1 host_req = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] off, input logic [31:0] v);
        int t, a, b, c, d, e, f, g; logic [15:0] w; logic [31:0] r;
        access(1'b1, {4'h0, off}, v, 0, t, a, b, c, d, e, f, w, r, g);
        chk(t == 0, "R2 register write ack latency", t, 0);
        if (off == 8'h00) ctrl_sh = v & 32'h0001_FEDF;
        if (off == 8'h08) com_sh = v;
        if (off == 8'h0C) att_sh = v;
    endtask

    task automatic reg_rd(input logic [7:0] off, input logic [31:0] exp, input string tag);
        int t, a, b, c, d, e, f, g; logic [15:0] w; logic [31:0] r;
        access(1'b0, {4'h0, off}, '0, 0, t, a, b, c, d, e, f, w, r, g);
        chk(r == exp, tag, r, exp);
    endtask

    // flash write with full checking
    task automatic flash_wr(input logic attr, input logic [1:0] win, input logic [15:0] d,
                            input int rb_rel, input int extra);
        int t, we, re, oe, cl, al, fr, bad; logic [15:0] w; logic [31:0] r;
        logic [31:0] tm; logic [15:0] expd; int drv;
        tm = tim_of(attr);
        access(1'b1, {1'b0, attr, win, 8'h00}, {16'h0, d}, rb_rel,
               t, we, re, oe, cl, al, fr, w, r, bad);
        drv = int'(tm[7:0]) + 1 + int'(tm[15:8]) + 1 + int'(tm[23:16]);
        expd = (ctrl_sh[4] && win == 2'b01) ? d : {8'h00, d[7:0]};
        chk(t == cycle_total(tm, 0) + extra, "R5 write cycle length", t, cycle_total(tm, 0) + extra);
        chk(we == int'(tm[15:8]) + 1, "R5 WE low length", we, int'(tm[15:8]) + 1);
        chk(oe == drv, "R5 bus drive length", oe, drv);
        chk(w == expd, "R9 write data lanes", w, expd);
        chk(cl == ((win == 2'b10) ? drv : 0), "R4 CLE window", cl, (win == 2'b10) ? drv : 0);
        chk(al == ((win == 2'b11) ? drv : 0), "R4 ALE window", al, (win == 2'b11) ? drv : 0);
        chk(bad == 0, "R10 strobe exclusivity", bad, 0);
        last_kind = win;
    endtask

    // flash read with full checking
    task automatic flash_rd(input logic attr, input logic [1:0] win, input logic [15:0] d);
        int t, we, re, oe, cl, al, fr, bad, dly; logic [15:0] w; logic [31:0] r;
        logic [31:0] tm, expr;
        tm = tim_of(attr);
        dly = turn_of(last_kind);
        nand_dq_in = d;
        access(1'b0, {1'b0, attr, win, 8'h00}, '0, 0, t, we, re, oe, cl, al, fr, w, r, bad);
        expr = ctrl_sh[4] ? {16'h0, d} : {24'h0, d[7:0]};
        chk(t == cycle_total(tm, dly), "R7 read cycle length", t, cycle_total(tm, dly));
        chk(fr == 2 + dly + int'(tm[7:0]), "R7 RE fall position", fr, 2 + dly + int'(tm[7:0]));
        chk(re == int'(tm[15:8]) + 1, "R6 RE low length", re, int'(tm[15:8]) + 1);
        chk(r == expr, "R6 R9 read data", r, expr);
        chk(cl == 0 && al == 0 && oe == 0, "R4 read drives no role", cl + al + oe, 0);
        chk(bad == 0, "R10 strobe exclusivity", bad, 0);
        last_kind = 2'b01;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        ctrl_sh = '0; com_sh = 32'h0104_0600; att_sh = 32'h0104_0600; last_kind = 2'b01;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
            "R1 pin reset state", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe},
            6'b111000);
        reg_rd(8'h00, 32'h0, "R1 control reset value");
        reg_rd(8'h08, 32'h0104_0600, "R1 common timing reset value");
        reg_rd(8'h0C, 32'h0104_0600, "R1 attribute timing reset value");

        // R2 reserved bits and unmapped offsets
        reg_wr(8'h00, 32'hFFFF_FFFF);
        reg_rd(8'h00, 32'h0001_FEDF, "R2 control reserved bits");
        chk(nand_ce_n == 1'b0, "R3 CE follows enable set", nand_ce_n, 0);
        reg_wr(8'h10, 32'hDEAD_BEEF);
        reg_rd(8'h10, 32'h0, "R2 unmapped offset reads zero");
        reg_rd(8'h04, 32'h0, "R2 status offset reads zero");
        reg_rd(8'h08, 32'h0104_0600, "R2 unmapped write ignored");
        reg_wr(8'h00, 32'h0);
        chk(nand_ce_n == 1'b1, "R3 CE follows enable clear", nand_ce_n, 1);

        // directed: distinct common and attribute timing, 8-bit then 16-bit
        reg_wr(8'h08, 32'h0201_0302);
        reg_wr(8'h0C, 32'h0003_0001);
        reg_wr(8'h00, 32'h0000_4614);      // en, wide, tclr=3, tar=2
        flash_wr(1'b0, 2'b10, 16'hA5C3, 0, 0);
        flash_rd(1'b0, 2'b01, 16'h1234);   // R7 after command: tclr
        flash_wr(1'b1, 2'b11, 16'hBEEF, 0, 0);
        flash_rd(1'b1, 2'b10, 16'h5678);   // R7 after address: tar
        flash_rd(1'b0, 2'b01, 16'h9ABC);   // R7 after read: none
        flash_wr(1'b0, 2'b01, 16'hCAFE, 0, 0);
        flash_rd(1'b1, 2'b01, 16'h0F0F);   // R7 after data write: none
        reg_wr(8'h00, 32'h0000_0004);      // 8-bit mode
        flash_wr(1'b0, 2'b01, 16'hCAFE, 0, 0);
        flash_rd(1'b0, 2'b01, 16'hF00D);

        // R8 wait-on-ready stall, then no effect when disabled
        reg_wr(8'h00, 32'h0000_0006);
        nand_rb_n = 1'b0;
        reg_rd(8'h00, 32'h0000_0006, "R8 register access while busy");
        flash_wr(1'b0, 2'b01, 16'h0055, 6, 5);
        reg_wr(8'h00, 32'h0000_0004);
        nand_rb_n = 1'b0;
        flash_wr(1'b0, 2'b10, 16'h0070, 0, 0);
        nand_rb_n = 1'b1;

        // random sequences
        for (int i = 0; i < 120; i++) begin
            int op; logic [1:0] win; logic at;
            op = int'($urandom_range(0, 5));
            win = 2'($urandom_range(1, 3));
            at = 1'($urandom_range(0, 1));
            if (op == 0) begin
                logic [31:0] c;
                c = {15'h0, 4'($urandom_range(0, 3)), 4'($urandom_range(0, 3)),
                     9'($urandom), 1'b0} | 32'h4;
                reg_wr(8'h00, c);
                reg_rd(8'h00, c & 32'h0001_FEDF, "R2 control readback");
            end else if (op == 1) begin
                logic [31:0] tv;
                tv = {8'($urandom_range(0, 3)), 8'($urandom_range(0, 3)),
                      8'($urandom_range(0, 3)), 8'($urandom_range(0, 3))};
                reg_wr(at ? 8'h0C : 8'h08, tv);
                reg_rd(at ? 8'h0C : 8'h08, tv, "R2 timing readback");
            end else if (op < 4) begin
                flash_wr(at, win, 16'($urandom), 0, 0);
            end else begin
                flash_rd(at, win, 16'($urandom));
            end
            chk(nand_ce_n == !ctrl_sh[2], "R3 CE tracks enable", nand_ce_n, !ctrl_sh[2]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule